// File: doc/BRIEF.md
# Four-Lane Parallel Direct Digital Synthesizer Core

This core generates a sampled sine wave for a converter that runs four times faster than the digital logic. Each slow clock it produces four consecutive output samples in time order. An external 1:4 serializer and a 14-bit current-steering converter take them from there. A 32-bit phase accumulator sets the output frequency, which is `tuning × f_dac / 2^32`. A phase offset shifts the waveform and a gain word scales it. The same core can serve as a cancellation source next to a main synthesizer, because its offset and gain can be rewritten and applied while it runs.

Settings are written into a shadow bank one field at a time. A commit strobe then moves the whole bank into the active set on one slow-clock edge, so a frequency change never meets an old phase or gain in the same cycle. Phase-to-amplitude conversion uses a parabolic sine approximation. The scaled result is rounded, clipped and presented in offset binary. When the core is disabled it outputs mid-scale, which is an analog zero.

Top module: `quad_dds_core`

## Requirements
- R1: While reset is held and on the first edge after its release, every lane reads 0x2000. Reset clears the active and shadow tuning and offset words to 0 and sets both gain words to unity, which is 256.
- R2: Lane k (0..3) is at bits [14k+13:14k] of `sample_o`. It uses phase `acc + k×tuning + (offset << 23)`, modulo 2^32. The output register updates one clock after the accumulator state it reflects.
- R3: While enabled, the accumulator advances by 4×tuning each clock with 32-bit wraparound. The phase of lane 0 in the next cycle therefore equals the phase of lane 3 plus the tuning word.
- R4: The top 12 bits of the lane phase form the table address. Address bit 11 selects the negative half-wave, and the low 11 bits x give the magnitude `(x × (2048 − x)) >> 7`, which is 0 to 8192.
- R5: The signed wave value is multiplied by the 9-bit gain, and the product is rounded half up: add 128, then floor-divide by 256. A gain of 256 is unity and a gain of 0 gives mid-scale.
- R6: The rounded value is clipped to the range −8192 to +8191.
- R7: The output code is the clipped value plus 8192, in offset binary.
- R8: `cfg_we_i` writes `cfg_data_i` into the shadow field chosen by `cfg_sel_i`. The selector codes are 0 for the 32-bit tuning word, 1 for the 9-bit offset in bits [8:0] and 2 for the 9-bit gain in bits [8:0]. Code 3 is ignored. Shadow writes change no output until `cfg_commit_i`, which copies all three fields on one edge. A write in the same cycle as a commit stays in the shadow bank.
- R9: While `en_i` is low, all lanes output 0x2000 from the next edge on and the accumulator is held at 0. After re-enable, the output restarts at phase 0 plus the offset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slow clock, one quarter of the converter rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| en_i | input | 1 | Run enable; low forces mid-scale and clears the accumulator |
| cfg_we_i | input | 1 | Shadow register write strobe |
| cfg_sel_i | input | 2 | Shadow field select: 0 tuning, 1 offset, 2 gain, 3 none |
| cfg_data_i | input | 32 | Shadow write data |
| cfg_commit_i | input | 1 | Copy the whole shadow bank into the active set |
| sample_o | output | 56 | Four 14-bit offset-binary samples, lane 0 (earliest) in the low bits |

## Verification
The core is driven with a zero tuning word at fixed offsets of a quarter and three quarters of a turn. The quarter-turn case tells positive clipping apart from the exactly representable negative full scale, and half gain exposes the rounding and scaling. Sweeps follow with a binary-fraction tuning word, an odd tuning word with an odd offset and above-unity gain, and a word near half the accumulator range. These separate the lane spacing, the carry between slow cycles and wraparound. Shadow writes without a commit, a write on the same edge as a commit, the ignored selector code, zero gain and a disable/enable cycle each show that state changes only where the requirements allow it.

// File: rtl/qdds_pkg.sv
package qdds_pkg;
  typedef enum logic [1:0] {
    SEL_FREQ  = 2'd0,
    SEL_PHASE = 2'd1,
    SEL_GAIN  = 2'd2,
    SEL_NONE  = 2'd3
  } cfg_sel_e;
endpackage

// File: rtl/qdds_cfg.sv
module qdds_cfg #(
  parameter int ACC_W = 32,
  parameter int POW_W = 9,
  parameter int ASF_W = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [1:0]       sel,
  input  logic [ACC_W-1:0] data,
  input  logic             commit,
  output logic [ACC_W-1:0] ftw_act,
  output logic [POW_W-1:0] pow_act,
  output logic [ASF_W-1:0] asf_act
);
  localparam logic [ASF_W-1:0] UNITY = {1'b1, {(ASF_W-1){1'b0}}};

  logic [ACC_W-1:0] ftw_sh;
  logic [POW_W-1:0] pow_sh;
  logic [ASF_W-1:0] asf_sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ftw_sh <= '0;
      pow_sh <= '0;
      asf_sh <= UNITY;
    end else if (we) begin
      case (qdds_pkg::cfg_sel_e'(sel))
        qdds_pkg::SEL_FREQ:  ftw_sh <= data;
        qdds_pkg::SEL_PHASE: pow_sh <= data[POW_W-1:0];
        qdds_pkg::SEL_GAIN:  asf_sh <= data[ASF_W-1:0];
        default: ;
      endcase
    end
  end

  // all three fields move together; a same-cycle write lands after the copy
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ftw_act <= '0;
      pow_act <= '0;
      asf_act <= UNITY;
    end else if (commit) begin
      ftw_act <= ftw_sh;
      pow_act <= pow_sh;
      asf_act <= asf_sh;
    end
  end
endmodule

// File: rtl/qdds_phase.sv
module qdds_phase #(
  parameter int ACC_W = 32,
  parameter int POW_W = 9,
  parameter int LANES = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   en,
  input  logic [ACC_W-1:0]       ftw,
  input  logic [POW_W-1:0]       pow,
  output logic [LANES*ACC_W-1:0] lane_ph
);
  logic [ACC_W-1:0] acc_q;
  logic [ACC_W-1:0] pow_ph;

  assign pow_ph = {pow, {(ACC_W-POW_W){1'b0}}};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   acc_q <= '0;
    else if (en)  acc_q <= acc_q + ftw * ACC_W'(LANES);
    else          acc_q <= '0;
  end

  for (genvar k = 0; k < LANES; k++) begin : g_lane_ph
    assign lane_ph[k*ACC_W +: ACC_W] = acc_q + ACC_W'(k) * ftw + pow_ph;
  end
endmodule

// File: rtl/qdds_lane.sv
module qdds_lane #(
  parameter int ACC_W = 32,
  parameter int TA    = 12,
  parameter int OUT_W = 14,
  parameter int ASF_W = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [ACC_W-1:0] phase,
  input  logic [ASF_W-1:0] asf,
  output logic [OUT_W-1:0] sample
);
  localparam int HW   = TA - 1;
  localparam int PW   = 2*HW + 1;
  localparam int SH   = 2*HW - 2 - (OUT_W - 1);
  localparam int PRW  = OUT_W + ASF_W + 2;
  localparam int HALF = 1 << (ASF_W - 2);
  localparam logic signed [PRW-1:0] MAXV = PRW'((1 << (OUT_W-1)) - 1);
  localparam logic signed [PRW-1:0] MINV = PRW'(-(1 << (OUT_W-1)));
  localparam logic [OUT_W-1:0] MID = {1'b1, {(OUT_W-1){1'b0}}};

  function automatic logic signed [OUT_W:0] wave_of(input logic [TA-1:0] a);
    logic [HW-1:0] x;
    logic [HW:0]   xc;
    logic [PW-1:0] m;
    logic [OUT_W:0] mm;
    x  = a[HW-1:0];
    xc = {1'b1, {HW{1'b0}}} - {1'b0, x};
    m  = {{(HW+1){1'b0}}, x} * {{HW{1'b0}}, xc};
    mm = m[SH +: OUT_W+1];
    return a[TA-1] ? -signed'(mm) : signed'(mm);
  endfunction

  function automatic logic [OUT_W-1:0] scale_of(input logic signed [OUT_W:0] w,
                                                input logic [ASF_W-1:0] g);
    logic signed [PRW-1:0] prod;
    logic signed [PRW-1:0] rnd;
    logic [OUT_W-1:0] c;
    prod = PRW'(w) * PRW'(signed'({1'b0, g}));
    rnd  = (prod + PRW'(HALF)) >>> (ASF_W - 1);
    if (rnd > MAXV)      c = MAXV[OUT_W-1:0];
    else if (rnd < MINV) c = MINV[OUT_W-1:0];
    else                 c = rnd[OUT_W-1:0];
    return {~c[OUT_W-1], c[OUT_W-2:0]};
  endfunction

  logic signed [OUT_W:0] wave;
  logic [OUT_W-1:0]      code;

  assign wave = wave_of(phase[ACC_W-1 -: TA]);
  assign code = scale_of(wave, asf);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   sample <= MID;
    else if (en)  sample <= code;
    else          sample <= MID;
  end
endmodule

// File: rtl/quad_dds_core.sv
module quad_dds_core #(
  parameter int ACC_W = 32,
  parameter int POW_W = 9,
  parameter int ASF_W = 9,
  parameter int TA    = 12,
  parameter int OUT_W = 14,
  parameter int LANES = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   en_i,
  input  logic                   cfg_we_i,
  input  logic [1:0]             cfg_sel_i,
  input  logic [ACC_W-1:0]       cfg_data_i,
  input  logic                   cfg_commit_i,
  output logic [LANES*OUT_W-1:0] sample_o
);
  logic [ACC_W-1:0]       ftw_act;
  logic [POW_W-1:0]       pow_act;
  logic [ASF_W-1:0]       asf_act;
  logic [LANES*ACC_W-1:0] lane_ph;

  qdds_cfg #(.ACC_W(ACC_W), .POW_W(POW_W), .ASF_W(ASF_W)) u_cfg (
    .clk(clk), .rst_n(rst_n), .we(cfg_we_i), .sel(cfg_sel_i),
    .data(cfg_data_i), .commit(cfg_commit_i),
    .ftw_act(ftw_act), .pow_act(pow_act), .asf_act(asf_act)
  );

  qdds_phase #(.ACC_W(ACC_W), .POW_W(POW_W), .LANES(LANES)) u_phase (
    .clk(clk), .rst_n(rst_n), .en(en_i), .ftw(ftw_act), .pow(pow_act),
    .lane_ph(lane_ph)
  );

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    qdds_lane #(.ACC_W(ACC_W), .TA(TA), .OUT_W(OUT_W), .ASF_W(ASF_W)) u_lane (
      .clk(clk), .rst_n(rst_n), .en(en_i),
      .phase(lane_ph[k*ACC_W +: ACC_W]), .asf(asf_act),
      .sample(sample_o[k*OUT_W +: OUT_W])
    );
  end
endmodule

// File: rtl/quad_dds_core_chk.sv
module quad_dds_core_chk #(
  parameter int ACC_W = 32,
  parameter int ASF_W = 9,
  parameter int OUT_W = 14,
  parameter int LANES = 4
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   en_i,
  input logic                   cfg_commit_i,
  input logic [LANES*OUT_W-1:0] sample_o,
  input logic [LANES*ACC_W-1:0] lane_ph,
  input logic [ACC_W-1:0]       ftw_act,
  input logic [ASF_W-1:0]       asf_act
);
  localparam logic [OUT_W-1:0] MID = {1'b1, {(OUT_W-1){1'b0}}};

  // R9
  off_mid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |=> sample_o == {LANES{MID}});

  // R3
  lane_carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && !cfg_commit_i) |=>
      lane_ph[ACC_W-1:0] == $past(lane_ph[(LANES-1)*ACC_W +: ACC_W]) + $past(ftw_act));

  // R8
  hold_cfg_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_commit_i |=> ($stable(ftw_act) && $stable(asf_act)));

  // R5
  zero_gain_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && asf_act == '0) |=> sample_o == {LANES{MID}});
endmodule

bind quad_dds_core quad_dds_core_chk #(
  .ACC_W(ACC_W), .ASF_W(ASF_W), .OUT_W(OUT_W), .LANES(LANES)
) u_chk (
  .clk(clk), .rst_n(rst_n), .en_i(en_i), .cfg_commit_i(cfg_commit_i),
  .sample_o(sample_o), .lane_ph(lane_ph), .ftw_act(ftw_act), .asf_act(asf_act)
);

// File: tb/quad_dds_core_tb.sv
module quad_dds_core_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        en_i = 1'b0;
  logic        cfg_we_i = 1'b0;
  logic [1:0]  cfg_sel_i = 2'd0;
  logic [31:0] cfg_data_i = '0;
  logic        cfg_commit_i = 1'b0;
  logic [55:0] sample_o;

  int    n_chk = 0;
  int    n_bad = 0;
  bit    done = 1'b0;
  string cur_tag = "R1";

  logic [55:0] exp_q[$];
  string       tag_q[$];

  // bench-side model state
  logic [31:0] m_acc = '0, m_ftw = '0, s_ftw = '0;
  int          m_pow = 0, m_asf = 256, s_pow = 0, s_asf = 256;

  always #4 clk = ~clk;

  quad_dds_core u_dut (
    .clk(clk), .rst_n(rst_n), .en_i(en_i), .cfg_we_i(cfg_we_i),
    .cfg_sel_i(cfg_sel_i), .cfg_data_i(cfg_data_i),
    .cfg_commit_i(cfg_commit_i), .sample_o(sample_o)
  );

  function automatic int expect_code(logic [31:0] ph, int gain);
    int a, x, mag, v, r;
    a   = int'(ph[31:20]);
    x   = a % 2048;
    mag = (x * (2048 - x)) / 128;
    v   = (a >= 2048) ? -mag : mag;
    r   = (v * gain + 128 + (1 << 30)) / 256 - (1 << 22);
    if (r > 8191)  r = 8191;
    if (r < -8192) r = -8192;
    return r + 8192;
  endfunction

  // driver-side predictor: pushes one expected word per edge
  always @(posedge clk) begin
    logic [55:0] e;
    for (int k = 0; k < 4; k++) begin
      if (!rst_n || !en_i) e[k*14 +: 14] = 14'h2000;
      else e[k*14 +: 14] = 14'(expect_code(m_acc + 32'(k) * m_ftw + (32'(m_pow) << 23), m_asf));
    end
    if (!rst_n) begin
      m_acc = '0; m_ftw = '0; s_ftw = '0;
      m_pow = 0; s_pow = 0; m_asf = 256; s_asf = 256;
    end else begin
      m_acc = en_i ? m_acc + 32'd4 * m_ftw : 32'd0;
      if (cfg_commit_i) begin
        m_ftw = s_ftw; m_pow = s_pow; m_asf = s_asf;
      end
      if (cfg_we_i) begin
        case (cfg_sel_i)
          2'd0: s_ftw = cfg_data_i;
          2'd1: s_pow = int'(cfg_data_i[8:0]);
          2'd2: s_asf = int'(cfg_data_i[8:0]);
          default: ;
        endcase
      end
    end
    exp_q.push_back(e);
    tag_q.push_back(cur_tag);
  end

  // monitor
  always @(negedge clk) begin
    if (exp_q.size() > 0 && !done) begin
      logic [55:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      n_chk++;
      if (sample_o !== e) begin
        n_bad++;
        $display("FAIL %s scoreboard: got %h expected %h", t, sample_o, e);
      end
    end
  end

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(logic [1:0] s, logic [31:0] d);
    cfg_we_i = 1'b1; cfg_sel_i = s; cfg_data_i = d;
    step(1);
    cfg_we_i = 1'b0;
  endtask

  task automatic commit();
    cfg_commit_i = 1'b1;
    step(1);
    cfg_commit_i = 1'b0;
  endtask

  task automatic direct(string t, logic [13:0] v);
    n_chk++;
    if (sample_o !== {4{v}}) begin
      n_bad++;
      $display("FAIL %s direct: got %h expected %h", t, sample_o, {4{v}});
    end
  endtask

  initial begin
    cur_tag = "R1";
    step(3);
    direct("R1", 14'h2000);
    rst_n = 1'b1;
    step(1);
    direct("R1", 14'h2000);

    cur_tag = "R4";
    en_i = 1'b1;
    step(4);
    direct("R4", 14'h2000);

    cur_tag = "R6";
    wr(2'd1, 32'd128); commit(); step(2);
    direct("R6", 14'h3FFF);
    wr(2'd1, 32'd384); commit(); step(2);
    direct("R7", 14'h0000);
    cur_tag = "R5";
    wr(2'd1, 32'd128); wr(2'd2, 32'd128); commit(); step(2);
    direct("R5", 14'h3000);
    wr(2'd2, 32'd0); commit(); step(2);
    direct("R5", 14'h2000);

    cur_tag = "R2";
    wr(2'd2, 32'd256); wr(2'd1, 32'd0); wr(2'd0, 32'h0400_0000); commit();
    step(40);

    cur_tag = "R8";
    wr(2'd0, 32'h0123_4567);
    step(6);
    wr(2'd3, 32'hFFFF_FFFF);
    step(3);
    cfg_we_i = 1'b1; cfg_sel_i = 2'd2; cfg_data_i = 32'd300; cfg_commit_i = 1'b1;
    step(1);
    cfg_we_i = 1'b0; cfg_commit_i = 1'b0;
    step(6);
    wr(2'd1, 32'd37); commit();
    cur_tag = "R6";
    step(60);

    cur_tag = "R9";
    en_i = 1'b0;
    step(2);
    direct("R9", 14'h2000);
    step(3);
    en_i = 1'b1;
    step(10);

    cur_tag = "R3";
    wr(2'd0, 32'h7FFF_FFFF); wr(2'd2, 32'd200); commit();
    step(50);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    #(200000 * 8);
    if (!done) begin
      done = 1'b1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule